// File: doc/BRIEF.md
# Key-Store Bring-Up Retry Controller

This controller brings a secured key-store engine out of power-down and decides whether it came up in a usable condition. It holds the engine in reset for a fixed number of cycles. It then asks an external power sequencer to switch the engine's RAM on and watches the engine's three status flags (busy, success, error). An all-zero status word is never a real status, so the controller first waits for any flag to appear. It then waits for busy to drop and judges the result together with the two permission flags (enrolment allowed, start allowed).

When the engine comes up badly, the controller escalates. A bad result means neither success nor error is set, or both permission flags are clear. On the first bad result it orders a power-down using the short discharge time and runs the whole bring-up again. On a second bad result it switches to the maximum discharge time and tries once more. The outcome of that third check is final: it is reported as good whenever success or error is set, whatever the permissions say. Every wait on the engine has a cycle limit. An expired limit ends the bring-up at once with a failure and no retry.

State machine: ENG_RESET (reset held) → POWER_UP (on command until done) → AWAIT_VALID (status non-zero) → AWAIT_IDLE (busy clear) → PASS, FAIL or POWER_DOWN (off command until done) → ENG_RESET. The transitions are: reset count reached; sequencer done; status valid or valid-timeout; busy clear with accept, with final report or with retry, or busy-timeout; sequencer done after power-down. PASS and FAIL are terminal until reset.

Top module: `kbc_bringup_ctrl`

## Requirements
- R1: The engine reset output is high for exactly RST_CYCLES consecutive cycles before every power-on command, and the power command is idle (2'b00) while it is high.
- R2: A power command (2'b01 = RAM on, 2'b10 = RAM off) stays unchanged until the cycle in which pwr_done_i is sampled high, and drops to idle in the next cycle.
- R3: After power-on the controller waits while busy, success and error are all zero; if this lasts WAIT_LIMIT evaluated cycles it asserts init_fail_o without any retry.
- R4: After a valid status the controller waits while busy is set; if busy is still set after WAIT_LIMIT evaluated cycles it asserts init_fail_o without any retry.
- R5: When busy clears with success or error set and at least one permission flag set, init_ok_o is asserted with no further power-cycle.
- R6: The first bad result issues a RAM-off command with discharge_o equal to SHORT_DISCHARGE, followed by a complete reset and power-on sequence.
- R7: A second bad result issues a second RAM-off command with discharge_o equal to MAX_DISCHARGE; no more than two RAM-off commands occur per bring-up.
- R8: After the second retry, the result is init_ok_o if success or error is set when busy clears, regardless of the permission flags, and init_fail_o otherwise.
- R9: init_ok_o and init_fail_o are never both high, stay high until reset once set, and the power command is idle and the engine reset low while either is high.
- R10: During reset the engine reset output is high, the power command is idle, both results are low and discharge_o equals SHORT_DISCHARGE.
- R11: If a wait's exit condition first holds in the last permitted cycle of its window, the exit wins over the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stat_busy_i | input | 1 | Engine busy flag |
| stat_ok_i | input | 1 | Engine success flag |
| stat_err_i | input | 1 | Engine error flag |
| allow_enrol_i | input | 1 | Engine permits enrolment |
| allow_start_i | input | 1 | Engine permits start |
| pwr_done_i | input | 1 | Power sequencer finished the current command |
| pwr_cmd_o | output | 2 | Power command: 00 idle, 01 RAM on, 10 RAM off |
| eng_rst_o | output | 1 | Reset to the key-store engine |
| discharge_o | output | DW | Discharge time in cycles for the RAM-off command |
| init_ok_o | output | 1 | Bring-up succeeded (sticky) |
| init_fail_o | output | 1 | Bring-up failed (sticky) |

## Verification
The wait-window timeout and the wait's own exit condition can fall in the same cycle. This happens when the status turns non-zero, or busy drops, exactly in the last evaluated cycle of the window. The bench provokes this with an engine model whose zero-status and busy phases run to exactly WAIT_LIMIT-1 and WAIT_LIMIT cycles, and then to one cycle more. It expects a normal pass on the first pair and an immediate failure without retry on the second. Random engine behaviour per attempt then mixes retries, permission outcomes and stuck engines, and each result is compared with a bench-computed expectation.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

    typedef enum logic [1:0] {
        PWR_IDLE = 2'b00,
        PWR_ON   = 2'b01,
        PWR_OFF  = 2'b10
    } pwr_cmd_e;

    typedef enum logic [2:0] {
        ST_ENG_RESET   = 3'd0,
        ST_POWER_UP    = 3'd1,
        ST_AWAIT_VALID = 3'd2,
        ST_AWAIT_IDLE  = 3'd3,
        ST_POWER_DOWN  = 3'd4,
        ST_PASS        = 3'd5,
        ST_FAIL        = 3'd6
    } bringup_state_e;

    typedef struct packed {
        logic busy;
        logic ok;
        logic err;
    } eng_status_t;

    localparam int RETRY_COUNT = 2;

endpackage

// File: rtl/kbc_cycle_timer.sv
module kbc_cycle_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_i,
    output logic [TW-1:0] count_o
);

    localparam logic [TW-1:0] TOP = {TW{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (restart_i) begin
            count_o <= '0;
        end else if (count_o != TOP) begin
            count_o <= count_o + 1'b1;
        end
    end

endmodule

// File: rtl/kbc_status_eval.sv
module kbc_status_eval
    import kbc_pkg::*;
(
    input  eng_status_t status_i,
    input  logic        allow_enrol_i,
    input  logic        allow_start_i,
    output logic        valid_o,
    output logic        busy_o,
    output logic        good_o,
    output logic        accept_o
);

    logic permitted;

    always_comb begin
        valid_o   = status_i.busy | status_i.ok | status_i.err;
        busy_o    = status_i.busy;
        good_o    = status_i.ok | status_i.err;
        permitted = allow_enrol_i | allow_start_i;
        accept_o  = good_o & permitted;
    end

endmodule

// File: rtl/kbc_retry_ctl.sv
module kbc_retry_ctl #(
    parameter int RETRIES         = 2,
    parameter int SHORT_DISCHARGE = 1000,
    parameter int MAX_DISCHARGE   = 5000,
    parameter int DW              = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance_i,
    output logic          last_o,
    output logic [DW-1:0] discharge_o
);

    localparam int AW = (RETRIES < 2) ? 1 : $clog2(RETRIES + 1);
    localparam logic [AW-1:0] LAST = AW'(RETRIES);
    localparam logic [DW-1:0] D_SHORT = DW'(SHORT_DISCHARGE);
    localparam logic [DW-1:0] D_MAX   = DW'(MAX_DISCHARGE);

    logic [AW-1:0] attempt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            attempt_q <= '0;
        end else if (advance_i && attempt_q != LAST) begin
            attempt_q <= attempt_q + 1'b1;
        end
    end

    always_comb begin
        last_o      = (attempt_q == LAST);
        discharge_o = (attempt_q == LAST) ? D_MAX : D_SHORT;
    end

endmodule

// File: rtl/kbc_bringup_ctrl.sv
module kbc_bringup_ctrl
    import kbc_pkg::*;
#(
    parameter int RST_CYCLES      = 16,
    parameter int SHORT_DISCHARGE = 20000,
    parameter int MAX_DISCHARGE   = 100000,
    parameter int WAIT_LIMIT      = 4096,
    localparam int DW = $clog2(MAX_DISCHARGE + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stat_busy_i,
    input  logic          stat_ok_i,
    input  logic          stat_err_i,
    input  logic          allow_enrol_i,
    input  logic          allow_start_i,
    input  logic          pwr_done_i,
    output logic [1:0]    pwr_cmd_o,
    output logic          eng_rst_o,
    output logic [DW-1:0] discharge_o,
    output logic          init_ok_o,
    output logic          init_fail_o
);

    localparam int LONGEST = (RST_CYCLES > WAIT_LIMIT) ? RST_CYCLES : WAIT_LIMIT;
    localparam int TW      = $clog2(LONGEST + 1);
    localparam logic [TW-1:0] RST_END  = TW'(RST_CYCLES - 1);
    localparam logic [TW-1:0] WAIT_END = TW'(WAIT_LIMIT - 1);

    bringup_state_e state_q, state_d;
    eng_status_t    status;
    logic           st_valid, st_busy, st_good, st_accept;
    logic [TW-1:0]  cnt;
    logic           restart;
    logic           retry_go;
    logic           last_try;

    assign status = '{busy: stat_busy_i, ok: stat_ok_i, err: stat_err_i};

    kbc_status_eval u_eval (
        .status_i      (status),
        .allow_enrol_i (allow_enrol_i),
        .allow_start_i (allow_start_i),
        .valid_o       (st_valid),
        .busy_o        (st_busy),
        .good_o        (st_good),
        .accept_o      (st_accept)
    );

    kbc_cycle_timer #(.TW(TW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .count_o   (cnt)
    );

    kbc_retry_ctl #(
        .RETRIES         (RETRY_COUNT),
        .SHORT_DISCHARGE (SHORT_DISCHARGE),
        .MAX_DISCHARGE   (MAX_DISCHARGE),
        .DW              (DW)
    ) u_retry (
        .clk         (clk),
        .rst_n       (rst_n),
        .advance_i   (retry_go),
        .last_o      (last_try),
        .discharge_o (discharge_o)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ENG_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d  = state_q;
        retry_go = 1'b0;
        unique case (state_q)
            ST_ENG_RESET: begin
                if (cnt == RST_END) state_d = ST_POWER_UP;
            end
            ST_POWER_UP: begin
                if (pwr_done_i) state_d = ST_AWAIT_VALID;
            end
            ST_AWAIT_VALID: begin
                if (st_valid)             state_d = ST_AWAIT_IDLE;
                else if (cnt == WAIT_END) state_d = ST_FAIL;
            end
            ST_AWAIT_IDLE: begin
                if (!st_busy) begin
                    if (st_accept) begin
                        state_d = ST_PASS;
                    end else if (last_try) begin
                        state_d = st_good ? ST_PASS : ST_FAIL;
                    end else begin
                        state_d  = ST_POWER_DOWN;
                        retry_go = 1'b1;
                    end
                end else if (cnt == WAIT_END) begin
                    state_d = ST_FAIL;
                end
            end
            ST_POWER_DOWN: begin
                if (pwr_done_i) state_d = ST_ENG_RESET;
            end
            ST_PASS: state_d = ST_PASS;
            ST_FAIL: state_d = ST_FAIL;
            default: state_d = ST_FAIL;
        endcase
    end

    assign restart = (state_d != state_q);

    // outputs
    always_comb begin
        pwr_cmd_o   = PWR_IDLE;
        eng_rst_o   = 1'b0;
        init_ok_o   = 1'b0;
        init_fail_o = 1'b0;
        unique case (state_q)
            ST_ENG_RESET:   eng_rst_o   = 1'b1;
            ST_POWER_UP:    pwr_cmd_o   = PWR_ON;
            ST_AWAIT_VALID: pwr_cmd_o   = PWR_IDLE;
            ST_AWAIT_IDLE:  pwr_cmd_o   = PWR_IDLE;
            ST_POWER_DOWN:  pwr_cmd_o   = PWR_OFF;
            ST_PASS:        init_ok_o   = 1'b1;
            ST_FAIL:        init_fail_o = 1'b1;
            default:        init_fail_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/kbc_bringup_checker.sv
module kbc_bringup_checker #(
    parameter int SHORT_DISCHARGE = 20000,
    parameter int MAX_DISCHARGE   = 100000,
    parameter int DW              = 17
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pwr_done_i,
    input logic [1:0]    pwr_cmd_o,
    input logic          eng_rst_o,
    input logic [DW-1:0] discharge_o,
    input logic          init_ok_o,
    input logic          init_fail_o
);

    logic [1:0] offs_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            offs_done <= '0;
        end else if (pwr_cmd_o == 2'b10 && pwr_done_i && offs_done != 2'd3) begin
            offs_done <= offs_done + 1'b1;
        end
    end

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_cmd_o != 2'b00 && !pwr_done_i) |=> (pwr_cmd_o == $past(pwr_cmd_o))); // R2
    AST_CMD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_cmd_o != 2'b00 && pwr_done_i) |=> (pwr_cmd_o == 2'b00)); // R2
    AST_ON_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eng_rst_o) |-> (pwr_cmd_o == 2'b01)); // R1
    AST_NO_CMD_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        eng_rst_o |-> (pwr_cmd_o == 2'b00)); // R1
    AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(init_ok_o && init_fail_o)); // R9
    AST_OK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        init_ok_o |=> init_ok_o); // R9
    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        init_fail_o |=> init_fail_o); // R9
    AST_QUIET_AFTER_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (init_ok_o || init_fail_o) |-> (pwr_cmd_o == 2'b00 && !eng_rst_o)); // R9
    AST_FIRST_OFF_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_cmd_o == 2'b10 && offs_done == 2'd0) |-> (discharge_o == DW'(SHORT_DISCHARGE))); // R6
    AST_SECOND_OFF_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_cmd_o == 2'b10 && offs_done == 2'd1) |-> (discharge_o == DW'(MAX_DISCHARGE))); // R7
    AST_OFF_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (offs_done == 2'd2) |-> (pwr_cmd_o != 2'b10)); // R7

endmodule

bind kbc_bringup_ctrl kbc_bringup_checker #(
    .SHORT_DISCHARGE (SHORT_DISCHARGE),
    .MAX_DISCHARGE   (MAX_DISCHARGE),
    .DW              (DW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_done_i  (pwr_done_i),
    .pwr_cmd_o   (pwr_cmd_o),
    .eng_rst_o   (eng_rst_o),
    .discharge_o (discharge_o),
    .init_ok_o   (init_ok_o),
    .init_fail_o (init_fail_o)
);

// File: tb/sim_kbc_bringup_ctrl.sv
`timescale 1ns/1ps
module sim_kbc_bringup_ctrl;

    localparam int RST  = 3;
    localparam int SHRT = 7;
    localparam int MAXD = 19;
    localparam int TMO  = 12;
    localparam int PLAT = 2;
    localparam int DW   = $clog2(MAXD + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stat_busy_i = 1'b0, stat_ok_i = 1'b0, stat_err_i = 1'b0;
    logic allow_enrol_i = 1'b0, allow_start_i = 1'b0;
    logic pwr_done_i = 1'b0;
    logic [1:0]    pwr_cmd_o;
    logic          eng_rst_o;
    logic [DW-1:0] discharge_o;
    logic          init_ok_o, init_fail_o;

    always #2.5 clk = ~clk;

    kbc_bringup_ctrl #(
        .RST_CYCLES (RST), .SHORT_DISCHARGE (SHRT),
        .MAX_DISCHARGE (MAXD), .WAIT_LIMIT (TMO)
    ) u0 (
        .clk (clk), .rst_n (rst_n),
        .stat_busy_i (stat_busy_i), .stat_ok_i (stat_ok_i), .stat_err_i (stat_err_i),
        .allow_enrol_i (allow_enrol_i), .allow_start_i (allow_start_i),
        .pwr_done_i (pwr_done_i), .pwr_cmd_o (pwr_cmd_o), .eng_rst_o (eng_rst_o),
        .discharge_o (discharge_o), .init_ok_o (init_ok_o), .init_fail_o (init_fail_o)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // per-attempt engine behaviour
    int zc [3];
    int bc [3];
    bit fok[3], fer[3], fen[3], fst[3];

    int off_cnt;

    task automatic chk(input bit cond, input string req, input string what, input int act, input int exp);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // expected {ok, retries}
    function automatic logic [2:0] expect_result();
        for (int a = 0; a < 3; a++) begin
            if (zc[a] >= TMO) return {1'b0, 2'(a)};
            if (bc[a] == 0 && !fok[a] && !fer[a]) return {1'b0, 2'(a)};
            if (bc[a] >= TMO + 1) return {1'b0, 2'(a)};
            if ((fok[a] || fer[a]) && (fen[a] || fst[a])) return {1'b1, 2'(a)};
            if (a == 2) return {fok[a] | fer[a], 2'd2};
        end
        return 3'b000;
    endfunction

    // power sequencer and engine model, plus port monitors
    initial begin
        int pcnt, k, ai, cur, rst_run, cmd_run;
        bit powered;
        logic [1:0] cmd, prev_cmd;
        pcnt = 0; k = 0; ai = 0; cur = 0; rst_run = 0; cmd_run = 0;
        powered = 0; prev_cmd = 2'b00; off_cnt = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                pcnt = 0; k = 0; ai = 0; cur = 0; rst_run = 0; cmd_run = 0;
                powered = 0; prev_cmd = 2'b00; off_cnt = 0;
                pwr_done_i = 0; stat_busy_i = 0; stat_ok_i = 0; stat_err_i = 0;
                allow_enrol_i = 0; allow_start_i = 0;
            end else begin
                cmd = pwr_cmd_o;
                if (cmd != 2'b00) cmd_run++;
                else if (cmd_run != 0) begin
                    chk(cmd_run == PLAT + 1, "R2", "command held cycles", cmd_run, PLAT + 1);
                    cmd_run = 0;
                end
                if (cmd == 2'b10 && prev_cmd != 2'b10) begin
                    if (off_cnt == 0) chk(discharge_o == DW'(SHRT), "R6", "first discharge", int'(discharge_o), SHRT);
                    else              chk(discharge_o == DW'(MAXD), "R7", "second discharge", int'(discharge_o), MAXD);
                    off_cnt++;
                end
                if (eng_rst_o) rst_run++;
                else if (rst_run != 0) begin
                    chk(rst_run == RST, "R1", "engine reset cycles", rst_run, RST);
                    chk(cmd == 2'b01, "R1", "command after reset", int'(cmd), 1);
                    rst_run = 0;
                end
                if (cmd == 2'b00) begin
                    pcnt = 0; pwr_done_i = 0;
                end else begin
                    pwr_done_i = (pcnt == PLAT);
                    pcnt++;
                end
                if (eng_rst_o || cmd == 2'b10) powered = 0;
                else if (cmd == 2'b01 && pwr_done_i) begin
                    powered = 1; k = 0; cur = ai; if (ai < 2) ai++;
                end else if (powered) k++;
                if (!powered || k <= zc[cur]) begin
                    stat_busy_i = 0; stat_ok_i = 0; stat_err_i = 0;
                end else if (k <= zc[cur] + bc[cur]) begin
                    stat_busy_i = 1; stat_ok_i = 0; stat_err_i = 0;
                end else begin
                    stat_busy_i = 0; stat_ok_i = fok[cur]; stat_err_i = fer[cur];
                end
                allow_enrol_i = powered ? fen[cur] : 1'b0;
                allow_start_i = powered ? fst[cur] : 1'b0;
                prev_cmd = cmd;
            end
        end
    end

    task automatic set_att(input int a, input int z, input int b, input bit ok, input bit er, input bit en, input bit st);
        zc[a] = z; bc[a] = b; fok[a] = ok; fer[a] = er; fen[a] = en; fst[a] = st;
    endtask

    task automatic run_case(input string tag);
        logic [2:0] exp;
        int n;
        exp = expect_result();
        rst_n = 0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
        n = 0;
        while (!(init_ok_o || init_fail_o) && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(init_ok_o == exp[2], tag, "init_ok", int'(init_ok_o), int'(exp[2]));
        chk(init_fail_o == !exp[2], tag, "init_fail", int'(init_fail_o), int'(!exp[2]));
        chk(off_cnt == int'(exp[1:0]), tag, "power-down count", off_cnt, int'(exp[1:0]));
        repeat (4) @(negedge clk);
        chk(init_ok_o == exp[2] && init_fail_o == !exp[2] && pwr_cmd_o == 2'b00 && !eng_rst_o,
            "R9", "result held and quiet", int'({init_ok_o, init_fail_o, pwr_cmd_o, eng_rst_o}),
            int'({exp[2], !exp[2], 3'b000}));
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int a = 0; a < 3; a++) set_att(a, 0, 0, 0, 0, 0, 0);
        repeat (3) @(posedge clk);
        #1;
        chk(eng_rst_o == 1'b1, "R10", "reset: engine reset", int'(eng_rst_o), 1);
        chk(pwr_cmd_o == 2'b00, "R10", "reset: command", int'(pwr_cmd_o), 0);
        chk(!init_ok_o && !init_fail_o, "R10", "reset: results", int'({init_ok_o, init_fail_o}), 0);
        chk(discharge_o == DW'(SHRT), "R10", "reset: discharge", int'(discharge_o), SHRT);

        // R5: first try good
        set_att(0, 2, 3, 1, 0, 1, 0); run_case("R5 first-try pass");
        // R5: error flag counts as valid, start permitted
        set_att(0, 0, 1, 0, 1, 0, 1); run_case("R5 error-flag pass");
        // R6: first try lacks permission, second good
        set_att(0, 1, 2, 1, 0, 0, 0); set_att(1, 1, 1, 1, 0, 0, 1); run_case("R6 one retry");
        // R7/R8: two retries, final has status but no permission -> ok
        set_att(0, 1, 1, 0, 0, 1, 1); set_att(1, 0, 2, 1, 0, 0, 0); set_att(2, 2, 2, 1, 0, 0, 0);
        run_case("R8 final without permission");
        // R8: final status empty -> fail
        set_att(2, 1, 2, 0, 0, 1, 1); run_case("R8 final bad");
        // R3 / R11: zero phase at limit
        set_att(0, TMO - 1, 1, 1, 0, 1, 1); run_case("R11 valid on last cycle");
        set_att(0, TMO, 1, 1, 0, 1, 1);     run_case("R3 valid timeout");
        // R4 / R11: busy phase at limit
        set_att(0, 0, TMO, 1, 0, 1, 1);     run_case("R11 busy clears on last cycle");
        set_att(0, 0, TMO + 1, 1, 0, 1, 1); run_case("R4 busy timeout");
        // R3: stuck in retry attempt
        set_att(0, 0, 1, 0, 0, 1, 1); set_att(1, TMO + 5, 0, 0, 0, 0, 0); run_case("R3 stuck on retry");

        for (int i = 0; i < 40; i++) begin
            for (int a = 0; a < 3; a++) begin
                int z, b;
                z = int'($urandom % 6);
                b = int'($urandom % 6);
                if ($urandom % 12 == 0) z = TMO + 2;
                if ($urandom % 15 == 0) b = TMO + 3;
                set_att(a, z, b, ($urandom % 3) == 0, ($urandom % 5) == 0,
                        ($urandom % 2) == 0, ($urandom % 3) == 0);
            end
            run_case("R5 random");
        end

        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual expired expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule